// File: doc/BRIEF.md
# Calendar Time-Date Counter

This block holds a running calendar: seconds, minutes, hours, day of month, month and a six-bit year offset. While it is enabled, it moves forward by exactly one second on each rising edge of a count strobe. That strobe comes from a prescaler elsewhere in the fabric and runs at 1 Hz. The year offset counts from a base year that must be a leap year, so any offset divisible by four is a leap year. Month lengths and February 29 follow from that rule.

All fields are packed into one 32-bit word, which is always visible on an output and can be loaded in one cycle through a write port. Hours are kept either in 24-hour form or in 12-hour form with a PM flag. A format bit selects between them, and that bit can only be changed while counting is disabled. After the last second of year offset 63, the count wraps to the first second of offset 0. The wrap produces a one-cycle pulse and sets a sticky flag, which software clears by writing a one.

Top module: `caltime_counter`

## Requirements
- R1: After reset the word reads 00:00:00 on day 1 of month 1, year offset 0, with 24-hour format selected and both overflow outputs low.
- R2: The word packs second[5:0], minute[11:6], hour[16:12], day[21:17], month[25:22] and year[31:26]. While `run_en` is high, each 0-to-1 change of `sec_strobe` advances the time by exactly one second, and a strobe held high for many cycles counts only once.
- R3: While `run_en` is low and no write occurs, the word does not change whatever `sec_strobe` does.
- R4: In 24-hour format (format bit 0), second 59 goes to 0 and carries into the minute. Minute 59 goes to 0 and carries into the hour. Hour 23 goes to 0 and carries into the day.
- R5: In 12-hour format (format bit 1), hour[16] is the PM flag and hour[15:12] runs 12, 1, 2 … 11. 11:59:59 AM is followed by 12:00:00 PM, 12:59:59 goes to 1:00:00 with the same flag, and 11:59:59 PM is followed by 12:00:00 AM on the next day.
- R6: Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year offset is divisible by four and 28 days otherwise. All other months have 31 days. After the last day of a month the day returns to 1, and month 12 is followed by month 1 of the next year offset.
- R7: One second after 23:59:59 on day 31 of month 12 in year offset 63, the word becomes 00:00:00 (12:00:00 AM in 12-hour form) on day 1 of month 1 in year offset 0. At the same moment `ovf_pulse` is high for one cycle and `ovf_flag` goes high.
- R8: `ovf_flag` stays high until a cycle with `ovf_clr` high clears it. If a wrap happens in the same cycle as a clear, the flag stays set.
- R9: A cycle with `wr_en` high loads all fields from `wr_data` at the next clock edge. This takes priority over an increment in that same cycle, and the increment is lost.
- R10: `fmt_wr` copies `fmt_12h_in` into the format bit only while `run_en` is low. While `run_en` is high the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counting enable; also locks the format bit |
| sec_strobe | input | 1 | 1 Hz count strobe, sampled on `clk` |
| wr_en | input | 1 | Load `wr_data` into the time word |
| wr_data | input | 32 | Packed time and date to load |
| fmt_wr | input | 1 | Write strobe for the format bit |
| fmt_12h_in | input | 1 | New format value (1 = 12-hour) |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| time_word | output | 32 | Current packed time and date |
| fmt_12h | output | 1 | Current format (1 = 12-hour) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle pulse on the year-63 wrap |

## Verification
Random starting times are biased toward second 59, minute 59, the last hour of each format and the last day of each month. This lets single increments and chained carries be told apart, and it checks every month's length against a reference model that routes hours through a 24-hour intermediate form. Directed cases separate leap from common Februaries and the two 12-hour boundaries (AM to PM versus PM to next day). They also cover the year-63 wrap with its pulse and flag, and a strobe held high versus a strobe pulsed. Coincident events test priority: a load and a strobe edge in the same cycle, and a clear and a wrap in the same cycle. Format writes made while running and while stopped show whether the lock works.

// File: rtl/caltime_pkg.sv
package caltime_pkg;
   localparam int WORD_W = 32;

   // Packed layout, MSB first: year, month, day, hour, minute, second
   typedef struct packed {
      logic [5:0] yr;
      logic [3:0] mon;
      logic [4:0] day;
      logic [4:0] hr;
      logic [5:0] mn;
      logic [5:0] sc;
   } cal_word_t;

   localparam logic [3:0] HR12_TOP   = 4'd12;
   localparam logic [4:0] HR24_LAST  = 5'd23;
   localparam logic [5:0] SEXA_LAST  = 6'd59;
   localparam logic [3:0] MON_LAST   = 4'd12;
   localparam logic [5:0] YEAR_LAST  = 6'h3F;
endpackage

// File: rtl/caltime_tick_edge.sv
module caltime_tick_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic rise
);
   logic level;
   logic level_q;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("caltime_tick_edge: SYNC_STAGES must be 0..3");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = strobe;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         logic [SYNC_STAGES:0]   ext;
         assign ext = {sh, strobe};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= ext[SYNC_STAGES-1:0];
         end
         assign level = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;
endmodule

// File: rtl/caltime_month_len.sv
module caltime_month_len #(
   parameter int LEAP_LOG2 = 2
) (
   input  logic [3:0] mon,
   input  logic [5:0] yr,
   output logic [4:0] last_day
);
   generate
      if (LEAP_LOG2 < 1 || LEAP_LOG2 > 6) begin : g_bad_leap
         $error("caltime_month_len: LEAP_LOG2 must be 1..6");
      end
   endgenerate

   logic leap;
   assign leap = (yr[LEAP_LOG2-1:0] == '0);

   always_comb begin
      case (mon)
         4'd2:                     last_day = leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:  last_day = 5'd30;
         default:                  last_day = 5'd31;
      endcase
   end
endmodule

// File: rtl/caltime_step.sv
module caltime_step
   import caltime_pkg::*;
#(
   parameter int LEAP_LOG2 = 2
) (
   input  cal_word_t cur,
   input  logic      fmt12,
   output cal_word_t nxt,
   output logic      wrap
);
   logic [4:0] last_day;
   logic       day_c;

   caltime_month_len #(.LEAP_LOG2(LEAP_LOG2)) u_len (
      .mon      (cur.mon),
      .yr       (cur.yr),
      .last_day (last_day)
   );

   always_comb begin
      nxt   = cur;
      wrap  = 1'b0;
      day_c = 1'b0;
      if (cur.sc >= SEXA_LAST) begin
         nxt.sc = '0;
         if (cur.mn >= SEXA_LAST) begin
            nxt.mn = '0;
            if (fmt12) begin
               if (cur.hr[3:0] == 4'd11) begin
                  nxt.hr = {~cur.hr[4], HR12_TOP};
                  day_c  = cur.hr[4];
               end else if (cur.hr[3:0] >= HR12_TOP) begin
                  nxt.hr = {cur.hr[4], 4'd1};
               end else begin
                  nxt.hr = {cur.hr[4], cur.hr[3:0] + 4'd1};
               end
            end else if (cur.hr >= HR24_LAST) begin
               nxt.hr = '0;
               day_c  = 1'b1;
            end else begin
               nxt.hr = cur.hr + 5'd1;
            end
         end else begin
            nxt.mn = cur.mn + 6'd1;
         end
      end else begin
         nxt.sc = cur.sc + 6'd1;
      end

      if (day_c) begin
         if (cur.day >= last_day) begin
            nxt.day = 5'd1;
            if (cur.mon >= MON_LAST) begin
               nxt.mon = 4'd1;
               nxt.yr  = cur.yr + 6'd1;
               wrap    = (cur.yr == YEAR_LAST);
            end else begin
               nxt.mon = cur.mon + 4'd1;
            end
         end else begin
            nxt.day = cur.day + 5'd1;
         end
      end
   end
endmodule

// File: rtl/caltime_counter.sv
module caltime_counter
   import caltime_pkg::*;
#(
   parameter int       SYNC_STAGES = 0,
   parameter int       LEAP_LOG2   = 2,
   parameter bit       RESET_FMT12 = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run_en,
   input  logic        sec_strobe,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   input  logic        fmt_wr,
   input  logic        fmt_12h_in,
   input  logic        ovf_clr,
   output logic [31:0] time_word,
   output logic        fmt_12h,
   output logic        ovf_flag,
   output logic        ovf_pulse
);
   localparam logic [4:0] RST_HR = RESET_FMT12 ? {1'b0, HR12_TOP} : 5'd0;
   localparam cal_word_t  RST_WORD = '{yr: 6'd0, mon: 4'd1, day: 5'd1,
                                       hr: RST_HR, mn: 6'd0, sc: 6'd0};

   generate
      if (WORD_W != $bits(cal_word_t)) begin : g_bad_word
         $error("caltime_counter: packed word width mismatch");
      end
   endgenerate

   cal_word_t now_q;
   cal_word_t nxt;
   logic      fmt_q;
   logic      ovf_q;
   logic      pulse_q;
   logic      rise;
   logic      wrap;
   logic      step;
   logic      wrap_hit;

   caltime_tick_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (sec_strobe),
      .rise   (rise)
   );

   caltime_step #(.LEAP_LOG2(LEAP_LOG2)) u_step (
      .cur   (now_q),
      .fmt12 (fmt_q),
      .nxt   (nxt),
      .wrap  (wrap)
   );

   assign step     = run_en & rise & ~wr_en;
   assign wrap_hit = step & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q   <= RST_WORD;
         fmt_q   <= RESET_FMT12;
         ovf_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (wr_en)     now_q <= cal_word_t'(wr_data);
         else if (step) now_q <= nxt;
         if (fmt_wr && !run_en) fmt_q <= fmt_12h_in;
         ovf_q   <= wrap_hit | (ovf_q & ~ovf_clr);
         pulse_q <= wrap_hit;
      end
   end

   assign time_word = now_q;
   assign fmt_12h   = fmt_q;
   assign ovf_flag  = ovf_q;
   assign ovf_pulse = pulse_q;
endmodule

// File: rtl/caltime_counter_chk.sv
module caltime_counter_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        run_en,
   input logic        sec_strobe,
   input logic        wr_en,
   input logic [31:0] wr_data,
   input logic        fmt_wr,
   input logic        fmt_12h_in,
   input logic        ovf_clr,
   input logic [31:0] time_word,
   input logic        fmt_12h,
   input logic        ovf_flag,
   input logic        ovf_pulse
);
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> time_word == $past(wr_data)); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_en) |=> $stable(time_word)); // R3
   AST_FMT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> $stable(fmt_12h)); // R10
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
   AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_clr |=> (!ovf_flag || ovf_pulse)); // R8
   AST_WRAP_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (time_word[31:17] == {6'd0, 4'd1, 5'd1}) && (time_word[11:0] == 12'd0)
                    && (time_word[16:12] == (fmt_12h ? 5'd12 : 5'd0))); // R7
   AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> ovf_flag); // R7
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse); // R7
endmodule

bind caltime_counter caltime_counter_chk u_chk (.*);

// File: tb/caltime_counter_test.sv
module caltime_counter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        sec_strobe = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        fmt_wr = 1'b0;
   logic        fmt_12h_in = 1'b0;
   logic        ovf_clr = 1'b0;
   logic [31:0] time_word;
   logic        fmt_12h;
   logic        ovf_flag;
   logic        ovf_pulse;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;

   caltime_counter uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .sec_strobe(sec_strobe),
      .wr_en(wr_en), .wr_data(wr_data), .fmt_wr(fmt_wr), .fmt_12h_in(fmt_12h_in),
      .ovf_clr(ovf_clr), .time_word(time_word), .fmt_12h(fmt_12h),
      .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
   );

   function automatic logic [31:0] mk(int y, int mo, int d, int h, int m, int s);
      return {y[5:0], mo[3:0], d[4:0], h[4:0], m[5:0], s[5:0]};
   endfunction

   function automatic int dim(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [31:0] model_next(logic [31:0] w, bit f12);
      int s, m, h, d, mo, y, hf;
      s = int'(w[5:0]); m = int'(w[11:6]); d = int'(w[21:17]);
      mo = int'(w[25:22]); y = int'(w[31:26]);
      if (f12) begin
         h = int'(w[15:12]);
         if (h == 12) h = 0;
         if (w[16]) h = h + 12;
      end else h = int'(w[16:12]);
      s++;
      if (s == 60) begin s = 0; m++; end
      if (m == 60) begin m = 0; h++; end
      if (h == 24) begin h = 0; d++; end
      if (d > dim(mo, y)) begin d = 1; mo++; end
      if (mo == 13) begin mo = 1; y++; end
      if (y == 64) y = 0;
      if (f12) begin
         hf = h % 12;
         if (hf == 0) hf = 12;
         if (h >= 12) hf = hf + 16;
      end else hf = h;
      return mk(y, mo, d, hf, m, s);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(logic [31:0] w);
      @(negedge clk); wr_en = 1'b1; wr_data = w;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic tick(int hold, output bit saw_pulse);
      @(negedge clk); sec_strobe = 1'b1;
      repeat (hold) @(negedge clk);
      saw_pulse = ovf_pulse;
      sec_strobe = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_fmt(bit f);
      @(negedge clk); fmt_wr = 1'b1; fmt_12h_in = f;
      @(negedge clk); fmt_wr = 1'b0;
   endtask

   task automatic step_check(string req, logic [31:0] start, bit f12);
      bit p;
      load(start);
      tick(1, p);
      chk(req, time_word, model_next(start, f12));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      bit p;
      logic [31:0] w, e;
      void'($urandom(32'h1DA7E));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 word", time_word, mk(0, 1, 1, 0, 0, 0));
      chk("R1 flags", {29'd0, fmt_12h, ovf_flag, ovf_pulse}, 32'd0);

      // R3 disabled: strobes ignored
      for (int i = 0; i < 3; i++) tick(1, p);
      chk("R3 idle", time_word, mk(0, 1, 1, 0, 0, 0));

      // R2 single step and held strobe
      run_en = 1'b1;
      tick(1, p);
      chk("R2 step", time_word, mk(0, 1, 1, 0, 0, 1));
      tick(6, p);
      chk("R2 held", time_word, mk(0, 1, 1, 0, 0, 2));

      // R4 24-hour carries
      step_check("R4 sec", mk(1, 3, 5, 7, 12, 59), 1'b0);
      step_check("R4 hour", mk(1, 3, 5, 23, 59, 59), 1'b0);
      chk("R4 day", time_word, mk(1, 3, 6, 0, 0, 0));

      // R6 month lengths and leap years
      step_check("R6 feb common", mk(1, 2, 28, 23, 59, 59), 1'b0);
      chk("R6 feb common abs", time_word, mk(1, 3, 1, 0, 0, 0));
      step_check("R6 feb leap", mk(4, 2, 28, 23, 59, 59), 1'b0);
      chk("R6 feb29 abs", time_word, mk(4, 2, 29, 0, 0, 0));
      step_check("R6 feb29 end", mk(4, 2, 29, 23, 59, 59), 1'b0);
      step_check("R6 apr", mk(9, 4, 30, 23, 59, 59), 1'b0);
      chk("R6 apr abs", time_word, mk(9, 5, 1, 0, 0, 0));
      step_check("R6 jan", mk(9, 1, 30, 23, 59, 59), 1'b0);
      chk("R6 jan31 abs", time_word, mk(9, 1, 31, 0, 0, 0));
      step_check("R6 year", mk(5, 12, 31, 23, 59, 59), 1'b0);
      chk("R6 year abs", time_word, mk(6, 1, 1, 0, 0, 0));

      // R7 wrap with overflow
      load(mk(63, 12, 31, 23, 59, 59));
      tick(1, p);
      chk("R7 epoch", time_word, mk(0, 1, 1, 0, 0, 0));
      chk("R7 pulse", {31'd0, p}, 32'd1);
      chk("R7 flag", {31'd0, ovf_flag}, 32'd1);
      chk("R7 pulse drops", {31'd0, ovf_pulse}, 32'd0);

      // R8 clear, then set wins over clear
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      chk("R8 cleared", {31'd0, ovf_flag}, 32'd0);
      load(mk(63, 12, 31, 23, 59, 59));
      @(negedge clk); sec_strobe = 1'b1; ovf_clr = 1'b1;
      @(negedge clk); sec_strobe = 1'b0; ovf_clr = 1'b0;
      chk("R8 set wins", {31'd0, ovf_flag}, 32'd1);
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;

      // R9 write beats increment
      w = mk(12, 7, 14, 10, 20, 30);
      @(negedge clk); sec_strobe = 1'b1; wr_en = 1'b1; wr_data = w;
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk); sec_strobe = 1'b0;
      @(negedge clk);
      chk("R9 priority", time_word, w);

      // R10 format lock
      set_fmt(1'b1);
      chk("R10 locked", {31'd0, fmt_12h}, 32'd0);
      run_en = 1'b0;
      set_fmt(1'b1);
      chk("R10 accepted", {31'd0, fmt_12h}, 32'd1);
      run_en = 1'b1;

      // R5 12-hour boundaries (hour field {pm, 1..12})
      step_check("R5 am to pm", mk(3, 5, 10, 11, 59, 59), 1'b1);
      chk("R5 noon abs", time_word, mk(3, 5, 10, 16 + 12, 0, 0));
      step_check("R5 pm to am", mk(3, 6, 30, 16 + 11, 59, 59), 1'b1);
      chk("R5 midnight abs", time_word, mk(3, 7, 1, 12, 0, 0));
      step_check("R5 twelve to one", mk(3, 6, 2, 16 + 12, 59, 59), 1'b1);
      chk("R5 one pm abs", time_word, mk(3, 6, 2, 16 + 1, 0, 0));
      load(mk(63, 12, 31, 16 + 11, 59, 59));
      tick(1, p);
      chk("R7 epoch 12h", time_word, mk(0, 1, 1, 12, 0, 0));
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;

      // Random runs against the model
      for (int it = 0; it < 60; it++) begin
         bit f;
         int y, mo, d, h, m, s, k;
         f = $urandom_range(1, 0) != 0;
         run_en = 1'b0;
         set_fmt(f);
         y = $urandom_range(63, 0);
         mo = $urandom_range(12, 1);
         d = ($urandom_range(3, 0) == 0) ? $urandom_range(dim(mo, y), 1) : dim(mo, y);
         s = ($urandom_range(1, 0) != 0) ? 59 : $urandom_range(59, 0);
         m = ($urandom_range(1, 0) != 0) ? 59 : $urandom_range(59, 0);
         if (f) begin
            h = ($urandom_range(1, 0) != 0) ? 11 : $urandom_range(12, 1);
            if ($urandom_range(1, 0) != 0) h = h + 16;
         end else h = ($urandom_range(1, 0) != 0) ? 23 : $urandom_range(23, 0);
         w = mk(y, mo, d, h, m, s);
         load(w);
         tick(1, p);
         chk("R3 random idle", time_word, w);
         run_en = 1'b1;
         k = $urandom_range(4, 1);
         e = w;
         for (int j = 0; j < k; j++) begin
            tick($urandom_range(3, 1), p);
            e = model_next(e, f);
            chk(f ? "R5 R6 random" : "R4 R6 random", time_word, e);
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule